// File: doc/BRIEF.md
# Optical Port Line Conditioner

This block sits between a UART and the two shared pins of an optical serial port. On the transmit side it can invert the UART output. It can then modulate the result with a carrier whose low-time fraction is selectable. A priority mux drives the transmit pin from one of four sources, or gives the pin to an LCD segment driver.

On the receive side the pin is routed to the UART, to a general-purpose input, or to a segment driver. An optional inversion applies to the UART path only. The carrier timing comes from a free-running phase counter that advances on a carrier tick enable.

Top module: `optport_cond`

## Requirements
- R1: The transmit inversion is applied before modulation. With inversion and modulation both on, a UART level of 1 produces the carrier and a UART level of 0 produces a steady 1.
- R2: With modulation on, a line level of 1 (after inversion) reaches the conditioned output unchanged. Only a line level of 0 is replaced by the carrier.
- R3: The carrier period is 16 ticks of `carrier_tick`, counted from phase 0. The carrier is low for the first 8, 4, 2 or 1 ticks of each period for `duty_code` 00, 01, 10 or 11, and high for the rest. Without a tick the phase holds.
- R4: A new `duty_code` takes effect only at the tick that wraps phase 15 to phase 0. The code present at that tick governs the whole next period. After reset the code in force is 00.
- R5: With `tx_seg_map`=0, `tx_src_sel` selects the transmit pin source: 00 `dio_out_val`, 01 the conditioned optical output, 10 `wpulse_in`, 11 `vpulse_in`.
- R6: With `tx_seg_map`=1 the transmit pin follows `seg_tx_drive`, and `tx_src_sel` has no effect.
- R7: With `rx_seg_map`=1 the receive pin belongs to the segment driver: `rx_seg_active`=1 and `rx_pad_out` follows `seg_rx_drive`, whatever `rx_disable` is. Otherwise `rx_seg_active`=0 and `rx_pad_out`=0.
- R8: With `rx_seg_map`=0, `rx_disable`=0 routes the pin to the UART as pin XOR `rx_invert`. `rx_disable`=1 routes it to `dio_in_val` uninverted, whatever `rx_invert` is.
- R9: Whenever the receive pin is not routed to the UART, `uart_rxd` is 1. Whenever it is not routed to the DIO input, `dio_in_val` is 0.
- R10: `uart_rxd` and `dio_in_val` are registered and lag their inputs by one clock. Reset sets them to 1 and 0, and sets the carrier phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_tick | input | 1 | Advances the carrier phase by one |
| duty_code | input | 2 | Carrier low-time selection |
| tx_invert | input | 1 | Invert UART transmit level |
| tx_mod_en | input | 1 | Enable carrier modulation |
| tx_src_sel | input | 2 | Transmit pin source select |
| tx_seg_map | input | 1 | Transmit pin owned by segment driver |
| uart_txd | input | 1 | UART transmit level |
| dio_out_val | input | 1 | General-purpose output value |
| wpulse_in | input | 1 | Real-energy pulse |
| vpulse_in | input | 1 | Reactive-energy pulse |
| seg_tx_drive | input | 1 | Segment drive for transmit pin |
| tx_pin | output | 1 | Transmit pin level |
| rx_pin | input | 1 | Receive pin level |
| rx_disable | input | 1 | Route receive pin to DIO instead of UART |
| rx_invert | input | 1 | Invert the UART receive path |
| rx_seg_map | input | 1 | Receive pin owned by segment driver |
| seg_rx_drive | input | 1 | Segment drive for receive pin |
| uart_rxd | output | 1 | Registered UART receive level |
| dio_in_val | output | 1 | Registered DIO input level |
| rx_seg_active | output | 1 | Receive pin is in segment mode |
| rx_pad_out | output | 1 | Segment level for receive pin |

## Verification
Two events can fall in the same clock: a `duty_code` write and the tick that wraps the carrier phase from 15 to 0. The bench provokes this by changing the code at the negative edge just before the wrapping edge. It also writes the code mid-period at phase 5, where the change must not take effect. The bench models phase and the code in force from its own tick count. It then judges every carrier cycle: the old low-time must hold until the wrap, and the new one must govern the whole period that follows.

// File: rtl/optport_pkg.sv
package optport_pkg;
  localparam int DUTY_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    TXS_DIO    = 2'b00,
    TXS_OPT    = 2'b01,
    TXS_WPULSE = 2'b10,
    TXS_VPULSE = 2'b11
  } tx_src_e;

  typedef enum logic [1:0] {
    RXR_UART = 2'b00,
    RXR_DIO  = 2'b01,
    RXR_SEG  = 2'b10
  } rx_route_e;

  // modulated line: ones pass, zeros take the carrier level
  function automatic logic modulate(input logic line, input logic mod_en,
                                    input logic carrier_hi);
    return line | (mod_en & carrier_hi);
  endfunction
endpackage

// File: rtl/opt_carrier.sv
module opt_carrier
  import optport_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DUTY_W-1:0] duty_code,
  output logic              carrier_hi,
  output logic              period_wrap
);
  localparam logic [PHASE_W:0] HALF = (PHASE_W+1)'(1) << (PHASE_W-1);

  logic [PHASE_W-1:0] phase_q;
  logic [DUTY_W-1:0]  duty_q;

  function automatic logic [PHASE_W:0] low_len(input logic [DUTY_W-1:0] d);
    return HALF >> d;
  endfunction

  assign period_wrap = tick && (phase_q == '1);
  assign carrier_hi  = ({1'b0, phase_q} >= low_len(duty_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      duty_q  <= '0;
    end else if (tick) begin
      phase_q <= phase_q + 1'b1;
      if (period_wrap) duty_q <= duty_code;
    end
  end

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wrap |=> $stable(duty_q));
  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase_q == PHASE_W'($past(phase_q) + 1'b1));
  // R3
  period_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == '0) |-> !carrier_hi);
endmodule

// File: rtl/opt_tx_path.sv
module opt_tx_path
  import optport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uart_txd,
  input  logic             tx_invert,
  input  logic             tx_mod_en,
  input  logic             carrier_hi,
  input  logic [SEL_W-1:0] tx_src_sel,
  input  logic             tx_seg_map,
  input  logic             dio_out_val,
  input  logic             wpulse_in,
  input  logic             vpulse_in,
  input  logic             seg_tx_drive,
  output logic             opt_tx,
  output logic             tx_pin
);
  logic line_val;

  assign line_val = uart_txd ^ tx_invert;
  assign opt_tx   = modulate(line_val, tx_mod_en, carrier_hi);

  always_comb begin
    if (tx_seg_map) begin
      tx_pin = seg_tx_drive;
    end else begin
      unique case (tx_src_e'(tx_src_sel))
        TXS_DIO:    tx_pin = dio_out_val;
        TXS_OPT:    tx_pin = opt_tx;
        TXS_WPULSE: tx_pin = wpulse_in;
        TXS_VPULSE: tx_pin = vpulse_in;
        default:    tx_pin = dio_out_val;
      endcase
    end
  end

  // R2
  one_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_val |-> opt_tx);
  // R6
  seg_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_seg_map |-> tx_pin == seg_tx_drive);
  // R5
  opt_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_seg_map && tx_src_sel == TXS_OPT) |-> tx_pin == opt_tx);
endmodule

// File: rtl/opt_rx_path.sv
module opt_rx_path
  import optport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic rx_disable,
  input  logic rx_invert,
  input  logic rx_seg_map,
  input  logic seg_rx_drive,
  output logic uart_rxd,
  output logic dio_in_val,
  output logic rx_seg_active,
  output logic rx_pad_out
);
  rx_route_e route;

  always_comb begin
    if (rx_seg_map)      route = RXR_SEG;
    else if (rx_disable) route = RXR_DIO;
    else                 route = RXR_UART;
  end

  assign rx_seg_active = (route == RXR_SEG);
  assign rx_pad_out    = rx_seg_active & seg_rx_drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uart_rxd   <= 1'b1;
      dio_in_val <= 1'b0;
    end else begin
      uart_rxd   <= (route == RXR_UART) ? (rx_pin ^ rx_invert) : 1'b1;
      dio_in_val <= (route == RXR_DIO) ? rx_pin : 1'b0;
    end
  end

  // R9
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route != RXR_UART) |=> uart_rxd);
  // R8
  dio_noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RXR_DIO) |=> dio_in_val == $past(rx_pin));
  // R7
  seg_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_seg_map |-> (rx_seg_active && rx_pad_out == seg_rx_drive));
endmodule

// File: rtl/optport_cond.sv
module optport_cond
  import optport_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_tick,
  input  logic [DUTY_W-1:0] duty_code,
  input  logic              tx_invert,
  input  logic              tx_mod_en,
  input  logic [SEL_W-1:0]  tx_src_sel,
  input  logic              tx_seg_map,
  input  logic              uart_txd,
  input  logic              dio_out_val,
  input  logic              wpulse_in,
  input  logic              vpulse_in,
  input  logic              seg_tx_drive,
  output logic              tx_pin,
  input  logic              rx_pin,
  input  logic              rx_disable,
  input  logic              rx_invert,
  input  logic              rx_seg_map,
  input  logic              seg_rx_drive,
  output logic              uart_rxd,
  output logic              dio_in_val,
  output logic              rx_seg_active,
  output logic              rx_pad_out
);
  logic carrier_hi;
  logic period_wrap;
  logic opt_tx;

  opt_carrier #(.PHASE_W(PHASE_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .tick(carrier_tick), .duty_code(duty_code),
    .carrier_hi(carrier_hi), .period_wrap(period_wrap)
  );

  opt_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .uart_txd(uart_txd), .tx_invert(tx_invert),
    .tx_mod_en(tx_mod_en), .carrier_hi(carrier_hi), .tx_src_sel(tx_src_sel),
    .tx_seg_map(tx_seg_map), .dio_out_val(dio_out_val), .wpulse_in(wpulse_in),
    .vpulse_in(vpulse_in), .seg_tx_drive(seg_tx_drive), .opt_tx(opt_tx),
    .tx_pin(tx_pin)
  );

  opt_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_disable(rx_disable),
    .rx_invert(rx_invert), .rx_seg_map(rx_seg_map), .seg_rx_drive(seg_rx_drive),
    .uart_rxd(uart_rxd), .dio_in_val(dio_in_val),
    .rx_seg_active(rx_seg_active), .rx_pad_out(rx_pad_out)
  );

  // R4
  wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_wrap |=> !carrier_hi);
endmodule

// File: tb/sim_optport_cond.sv
`timescale 1ns/1ps
module sim_optport_cond;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier_tick = 1'b0;
  logic [1:0] duty_code = 2'b00;
  logic tx_invert = 0, tx_mod_en = 0, tx_seg_map = 0;
  logic [1:0] tx_src_sel = 2'b00;
  logic uart_txd = 1, dio_out_val = 0, wpulse_in = 0, vpulse_in = 0, seg_tx_drive = 0;
  logic rx_pin = 1, rx_disable = 0, rx_invert = 0, rx_seg_map = 0, seg_rx_drive = 0;
  logic tx_pin, uart_rxd, dio_in_val, rx_seg_active, rx_pad_out;

  always #2 clk = ~clk;

  optport_cond u0 (
    .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .duty_code(duty_code),
    .tx_invert(tx_invert), .tx_mod_en(tx_mod_en), .tx_src_sel(tx_src_sel),
    .tx_seg_map(tx_seg_map), .uart_txd(uart_txd), .dio_out_val(dio_out_val),
    .wpulse_in(wpulse_in), .vpulse_in(vpulse_in), .seg_tx_drive(seg_tx_drive),
    .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_disable(rx_disable), .rx_invert(rx_invert),
    .rx_seg_map(rx_seg_map), .seg_rx_drive(seg_rx_drive), .uart_rxd(uart_rxd),
    .dio_in_val(dio_in_val), .rx_seg_active(rx_seg_active), .rx_pad_out(rx_pad_out)
  );

  typedef struct { int kind; logic exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench view of carrier and registered receive values
  logic [3:0] ph = 0;
  logic [1:0] duty_eff = 0;
  logic exp_uart = 1, exp_dio = 0;

  task automatic push(int kind, logic exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // advance one clock; update the bench model from inputs held over the edge
  task automatic step();
    logic nu, nd;
    nu = (!rx_seg_map && !rx_disable) ? (rx_pin ^ rx_invert) : 1'b1;
    nd = (!rx_seg_map && rx_disable) ? rx_pin : 1'b0;
    @(negedge clk);
    if (carrier_tick) begin
      if (ph == 4'd15) duty_eff = duty_code;
      ph = ph + 4'd1;
    end
    exp_uart = nu;
    exp_dio  = nd;
  endtask

  function automatic logic carrier_exp();
    int lowt;
    lowt = 8 / (1 << duty_eff);
    return (int'(ph) >= lowt);
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic act;
        it = q.pop_front();
        case (it.kind)
          0: act = tx_pin;
          1: act = uart_rxd;
          2: act = dio_in_val;
          3: act = rx_seg_active;
          default: act = rx_pad_out;
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%b expected=%b t=%0t",
                   it.tag, it.kind, act, it.exp, $time);
        end
      end
    end
  end

  // driver
  initial begin
    carrier_tick = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ph = 0; duty_eff = 0; exp_uart = 1; exp_dio = 0;
    // R10 reset state
    push(1, 1'b1, "R10 reset uart_rxd");
    push(2, 1'b0, "R10 reset dio_in_val");
    push(3, 1'b0, "R7 reset rx_seg_active");
    push(0, carrier_exp(), "R10 reset phase");
    tx_src_sel = 2'b01; tx_mod_en = 1; uart_txd = 0;
    push(0, 1'b0, "R3 phase0 low");
    step();

    // R5 source select
    tx_mod_en = 0; uart_txd = 0; tx_invert = 0;
    for (int pass = 0; pass < 2; pass++) begin
      dio_out_val = (pass == 0); wpulse_in = (pass == 1); vpulse_in = (pass == 0);
      for (int s = 0; s < 4; s++) begin
        tx_src_sel = 2'(s);
        case (s)
          0: push(0, dio_out_val, "R5 sel dio");
          1: push(0, 1'b0, "R5 sel opt");
          2: push(0, wpulse_in, "R5 sel wpulse");
          default: push(0, vpulse_in, "R5 sel vpulse");
        endcase
        step();
      end
    end

    // R6 segment ownership ignores the select
    tx_seg_map = 1;
    for (int s = 0; s < 8; s++) begin
      tx_src_sel = 2'(s); seg_tx_drive = s[0] ^ s[2];
      push(0, seg_tx_drive, "R6 seg owns tx");
      step();
    end
    tx_seg_map = 0; tx_src_sel = 2'b01;

    // R3 each duty code over a full period
    tx_mod_en = 1; tx_invert = 0; uart_txd = 0;
    for (int d = 0; d < 4; d++) begin
      duty_code = 2'(d);
      while (!(duty_eff == 2'(d) && ph == 0)) step();
      for (int k = 0; k < 16; k++) begin
        push(0, carrier_exp(), "R3 carrier shape");
        step();
      end
    end
    // R3 phase holds without ticks
    carrier_tick = 0;
    for (int k = 0; k < 5; k++) begin
      push(0, carrier_exp(), "R3 no tick hold");
      step();
    end
    carrier_tick = 1;

    // R1 inversion before modulation
    tx_invert = 1; uart_txd = 1;
    for (int k = 0; k < 16; k++) begin
      push(0, carrier_exp(), "R1 inverted one modulated");
      step();
    end
    uart_txd = 0;
    for (int k = 0; k < 4; k++) begin
      push(0, 1'b1, "R1 inverted zero passes");
      step();
    end
    // R2 ones pass under modulation
    tx_invert = 0; uart_txd = 1;
    for (int k = 0; k < 16; k++) begin
      push(0, 1'b1, "R2 one passes");
      step();
    end

    // R4 mid-period change and change coinciding with wrap
    uart_txd = 0;
    while (ph != 4'd5) step();
    duty_code = 2'b00;
    for (int k = 0; k < 20; k++) begin
      push(0, carrier_exp(), "R4 mid-period write");
      step();
    end
    while (ph != 4'd15) step();
    duty_code = 2'b10;
    for (int k = 0; k < 18; k++) begin
      push(0, carrier_exp(), "R4 write on wrap");
      step();
    end

    // receive routing over all control combinations
    for (int c = 0; c < 32; c++) begin
      rx_pin = c[0]; rx_invert = c[1]; rx_disable = c[2]; rx_seg_map = c[3];
      seg_rx_drive = c[4];
      push(1, exp_uart, "R10 uart lag");
      push(2, exp_dio, "R10 dio lag");
      push(3, rx_seg_map, "R7 seg active");
      push(4, rx_seg_map & seg_rx_drive, "R7 pad out");
      step();
      if (rx_seg_map || rx_disable) push(1, exp_uart, "R9 uart idle");
      else push(1, exp_uart, "R8 uart path");
      if (!rx_seg_map && rx_disable) push(2, exp_dio, "R8 dio no invert");
      else push(2, exp_dio, "R9 dio idle");
      step();
    end

    repeat (2) step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule